// File: doc/BRIEF.md
# Virtual Channel Input Port Buffer

This block is the receive side of one router input port. A single physical link delivers at most one flit per cycle. Each flit carries a virtual-channel index and a two-bit kind, and the block writes it into a separate queue for that virtual channel. Because every channel has its own queue, a packet that stalls on one channel leaves the other channels free to drain.

A downstream arbiter, which is not part of this block, reads the port. It presents a channel select and a read enable. The front flit of the selected channel appears combinationally in the same cycle, and the enable pops it at the clock edge.

Each channel is owned by one packet at a time. Ownership starts when the head flit is accepted and ends when the tail flit leaves. Each successful pop produces a one-cycle credit pulse tagged with the channel, which the upstream credit counter uses. Two sticky error flags are also provided: one for writes to a full queue, one for a head flit that arrives on an owned channel.

Top module: `vc_input_port`

## Requirements
- R1: After a synchronous active-high reset the block is in this state: every queue empty, every count zero, no channel owned, both error flags low and `credit_valid` low.
- R2: A flit presented with `in_valid` on a channel whose queue is not full is stored in that channel's queue. That count rises by one in the next cycle, and the counts of the other channels do not change.
- R3: The read side works as follows:
  - `rd_valid` shows in the same cycle whether the channel chosen by `rd_vc` holds a flit.
  - `rd_kind` and `rd_data` show that channel's oldest flit.
  - Flits of one channel leave in the order they arrived.
- R4: A read enable on an empty channel is ignored. No count changes and no credit pulse follows.
- R5: Each successful pop drives `credit_valid` high for exactly the following cycle, with `credit_vc` equal to the channel that was popped. `credit_valid` is low after any cycle without a pop.
- R6: A write to a queue that already holds DEPTH flits is dropped and sets `overflow_err`, which stays set until reset. This holds even when the same channel is popped in that cycle.
- R7: While one channel's queue is full and never read, flits on another channel are still written, read and credited normally.
- R8: Kind encoding is 00 body, 01 head, 10 tail, 11 head-and-tail. Ownership follows these rules:
  - An accepted head or head-and-tail flit marks its channel owned in `vc_busy`.
  - A pop of a tail or head-and-tail flit releases the channel.
  - If both happen to one channel in the same cycle, the channel stays owned.
  - Body flits leave ownership unchanged.
- R9: A head or head-and-tail flit arriving on a channel that is owned in that cycle sets `proto_err`, which stays set until reset. The flit is still stored if there is room.
- R10: A write and a pop on the same non-full, non-empty channel in one cycle both take effect, and that channel's count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A flit is present on the link this cycle |
| in_vc | input | VC_W | Channel index of the arriving flit |
| in_kind | input | 2 | Flit kind (00 body, 01 head, 10 tail, 11 head-and-tail) |
| in_data | input | DATA_W | Flit payload |
| rd_en | input | 1 | Pop the front flit of the selected channel |
| rd_vc | input | VC_W | Channel selected by the downstream arbiter |
| rd_valid | output | 1 | Selected channel holds at least one flit |
| rd_kind | output | 2 | Kind of the selected channel's front flit |
| rd_data | output | DATA_W | Payload of the selected channel's front flit |
| vc_nonempty | output | NUM_VC | One bit per channel, set when its queue is not empty |
| vc_count | output | NUM_VC*CNT_W | Occupancy per channel; channel v sits at bits v*CNT_W upward |
| vc_busy | output | NUM_VC | One bit per channel, set while a packet owns it |
| credit_valid | output | 1 | One-cycle pulse following each pop |
| credit_vc | output | VC_W | Channel the credit belongs to; meaningful while credit_valid is high |
| overflow_err | output | 1 | Sticky: a write hit a full queue |
| proto_err | output | 1 | Sticky: a head flit arrived on an owned channel |

## Verification
The bench builds the block with two channels of three flits each and an 8-bit payload. With these values every queue can be driven from empty to full and then into overflow within a few cycles.

The bench sweeps all 64 combinations of write-valid, write channel, flit kind, read enable and read channel, in several reordered passes. This places every ownership transition next to every occupancy level, including:
- a head flit racing a tail pop;
- a write to a full queue during a pop.

An arithmetic queue model in the bench predicts every output cycle by cycle. Short directed sequences isolate empty reads, a channel blocked while full, and simultaneous write and read.

// File: rtl/vc_port_pkg.sv
package vc_port_pkg;

    typedef enum logic [1:0] {
        FK_BODY   = 2'b00,
        FK_HEAD   = 2'b01,
        FK_TAIL   = 2'b10,
        FK_SINGLE = 2'b11
    } flit_kind_e;

    function automatic logic opens_packet(input flit_kind_e k);
        return (k == FK_HEAD) || (k == FK_SINGLE);
    endfunction

    function automatic logic closes_packet(input flit_kind_e k);
        return (k == FK_TAIL) || (k == FK_SINGLE);
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vc_flit_fifo.sv
module vc_flit_fifo #(
    parameter int DEPTH = 3,
    parameter int WIDTH = 10,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = vc_port_pkg::idx_width(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= advance(wr_ptr);
            end
            if (do_pop) rd_ptr <= advance(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_full_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));

    assert_full_drop_pop_R6: assert property (@(posedge clk) disable iff (rst)
        (push && full && pop) |=> (count == CNT_W'(DEPTH - 1)));

    assert_same_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !full && !empty) |=> (count == $past(count)));

endmodule

// File: rtl/vc_owner_track.sv
module vc_owner_track
    import vc_port_pkg::*;
#(
    parameter int NUM_VC = 2,
    parameter int VC_W   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VC_W-1:0]   in_vc,
    input  flit_kind_e        in_kind,
    input  logic              wr_full_sel,
    input  logic              rd_fire,
    input  logic [VC_W-1:0]   rd_vc,
    input  flit_kind_e        rd_kind,
    output logic [NUM_VC-1:0] busy,
    output logic              proto_err
);
    logic [NUM_VC-1:0] busy_nxt;
    logic              cur_busy;
    logic              head_in;

    assign head_in = in_valid && opens_packet(in_kind);

    always_comb begin
        busy_nxt = busy;
        cur_busy = 1'b0;
        for (int v = 0; v < NUM_VC; v++) begin
            if (in_vc == VC_W'(v)) cur_busy = busy[v];
            if (rd_fire && rd_vc == VC_W'(v) && closes_packet(rd_kind))
                busy_nxt[v] = 1'b0;
            if (head_in && !wr_full_sel && in_vc == VC_W'(v))
                busy_nxt[v] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= '0;
            proto_err <= 1'b0;
        end else begin
            busy <= busy_nxt;
            if (head_in && cur_busy) proto_err <= 1'b1;
        end
    end

    assert_head_claims_R8: assert property (@(posedge clk) disable iff (rst)
        (head_in && !wr_full_sel && in_vc == VC_W'(0)) |=> busy[0]);

    assert_body_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_fire && !head_in) |=> (busy == $past(busy)));

    assert_proto_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

endmodule

// File: rtl/vc_input_port.sv
module vc_input_port
    import vc_port_pkg::*;
#(
    parameter int NUM_VC = 2,
    parameter int DEPTH  = 3,
    parameter int DATA_W = 16,
    parameter int VC_W   = vc_port_pkg::idx_width(NUM_VC),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [VC_W-1:0]          in_vc,
    input  logic [1:0]               in_kind,
    input  logic [DATA_W-1:0]        in_data,
    input  logic                     rd_en,
    input  logic [VC_W-1:0]          rd_vc,
    output logic                     rd_valid,
    output logic [1:0]               rd_kind,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_VC-1:0]        vc_nonempty,
    output logic [NUM_VC*CNT_W-1:0]  vc_count,
    output logic [NUM_VC-1:0]        vc_busy,
    output logic                     credit_valid,
    output logic [VC_W-1:0]          credit_vc,
    output logic                     overflow_err,
    output logic                     proto_err
);
    localparam int FW = DATA_W + 2;

    logic [NUM_VC-1:0] push, pop, full, empty;
    logic [FW-1:0]     dout [NUM_VC];
    logic [FW-1:0]     front;
    logic              wr_full_sel;
    logic              rd_fire;

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        assign push[v] = in_valid && (in_vc == VC_W'(v));
        assign pop[v]  = rd_en && (rd_vc == VC_W'(v));

        vc_flit_fifo #(.DEPTH(DEPTH), .WIDTH(FW), .CNT_W(CNT_W)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (push[v]),
            .pop   (pop[v]),
            .din   ({in_kind, in_data}),
            .dout  (dout[v]),
            .count (vc_count[v*CNT_W +: CNT_W]),
            .full  (full[v]),
            .empty (empty[v])
        );
    end

    assign vc_nonempty = ~empty;

    always_comb begin
        rd_valid    = 1'b0;
        front       = '0;
        wr_full_sel = 1'b0;
        for (int v = 0; v < NUM_VC; v++) begin
            if (rd_vc == VC_W'(v)) begin
                rd_valid = !empty[v];
                front    = dout[v];
            end
            if (in_vc == VC_W'(v)) wr_full_sel = full[v];
        end
    end

    assign rd_kind = front[FW-1 -: 2];
    assign rd_data = front[DATA_W-1:0];
    assign rd_fire = rd_en && rd_valid;

    vc_owner_track #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_owner (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_vc       (in_vc),
        .in_kind     (flit_kind_e'(in_kind)),
        .wr_full_sel (wr_full_sel),
        .rd_fire     (rd_fire),
        .rd_vc       (rd_vc),
        .rd_kind     (flit_kind_e'(rd_kind)),
        .busy        (vc_busy),
        .proto_err   (proto_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            credit_valid <= 1'b0;
            credit_vc    <= '0;
            overflow_err <= 1'b0;
        end else begin
            credit_valid <= rd_fire;
            credit_vc    <= rd_vc;
            if (in_valid && wr_full_sel) overflow_err <= 1'b1;
        end
    end

    assert_credit_follows_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && vc_nonempty[rd_vc]) |=> (credit_valid && credit_vc == $past(rd_vc)));

    assert_no_credit_empty_R4: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && vc_nonempty[rd_vc]) |=> !credit_valid);

    assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        overflow_err |=> overflow_err);

    assert_full_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wr_full_sel) |=> overflow_err);

endmodule

// File: tb/vc_input_port_tb.sv
module vc_input_port_tb;
    localparam int NV = 2;
    localparam int DP = 3;
    localparam int DW = 8;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [0:0]    in_vc;
    logic [1:0]    in_kind;
    logic [DW-1:0] in_data;
    logic          rd_en;
    logic [0:0]    rd_vc;
    logic          rd_valid;
    logic [1:0]    rd_kind;
    logic [DW-1:0] rd_data;
    logic [NV-1:0] vc_nonempty;
    logic [NV*CW-1:0] vc_count;
    logic [NV-1:0] vc_busy;
    logic          credit_valid;
    logic [0:0]    credit_vc;
    logic          overflow_err;
    logic          proto_err;

    always #4 clk = ~clk;

    vc_input_port #(.NUM_VC(NV), .DEPTH(DP), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vc(in_vc),
        .in_kind(in_kind), .in_data(in_data), .rd_en(rd_en), .rd_vc(rd_vc),
        .rd_valid(rd_valid), .rd_kind(rd_kind), .rd_data(rd_data),
        .vc_nonempty(vc_nonempty), .vc_count(vc_count), .vc_busy(vc_busy),
        .credit_valid(credit_valid), .credit_vc(credit_vc),
        .overflow_err(overflow_err), .proto_err(proto_err)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [9:0] mq [NV][DP];
    int         mcnt [NV];
    logic       mbusy [NV];
    logic       movf, mpro, mcv;
    int         mcvc;
    logic [7:0] dctr = 8'h10;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_state();
        for (int v = 0; v < NV; v++) begin
            chk(int'(vc_count[v*CW +: CW]) == mcnt[v], "R2 count",
                int'(vc_count[v*CW +: CW]), mcnt[v]);
            chk(vc_nonempty[v] == (mcnt[v] > 0), "R2 nonempty",
                int'(vc_nonempty[v]), int'(mcnt[v] > 0));
            chk(vc_busy[v] == mbusy[v], "R8 busy", int'(vc_busy[v]), int'(mbusy[v]));
        end
        chk(credit_valid == mcv, "R5 credit_valid", int'(credit_valid), int'(mcv));
        if (mcv) chk(int'(credit_vc) == mcvc, "R5 credit_vc", int'(credit_vc), mcvc);
        chk(overflow_err == movf, "R6 overflow_err", int'(overflow_err), int'(movf));
        chk(proto_err == mpro, "R9 proto_err", int'(proto_err), int'(mpro));
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; in_vc = '0; in_kind = '0; in_data = '0;
        rd_en = 1'b0; rd_vc = '0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        for (int v = 0; v < NV; v++) begin mcnt[v] = 0; mbusy[v] = 1'b0; end
        movf = 1'b0; mpro = 1'b0; mcv = 1'b0; mcvc = 0;
        chk(vc_count == '0 && vc_nonempty == '0 && vc_busy == '0, "R1 queues",
            int'({vc_count, vc_nonempty, vc_busy}), 0);
        chk(!credit_valid && !overflow_err && !proto_err, "R1 flags",
            int'({credit_valid, overflow_err, proto_err}), 0);
    endtask

    task automatic step(input bit iv, input int ivc, input int ik, input bit re, input int rv);
        logic [9:0] fl, fr;
        bit rd_ok, wr_ok, wr_full;
        in_valid = iv; in_vc = 1'(ivc); in_kind = 2'(ik); in_data = dctr;
        rd_en = re; rd_vc = 1'(rv);
        fl = {2'(ik), dctr};
        dctr = dctr + 8'd1;
        #2;
        chk(rd_valid == (mcnt[rv] > 0), "R3 rd_valid", int'(rd_valid), int'(mcnt[rv] > 0));
        if (mcnt[rv] > 0)
            chk({rd_kind, rd_data} == mq[rv][0], "R3 front flit",
                int'({rd_kind, rd_data}), int'(mq[rv][0]));
        @(posedge clk);
        #1;
        fr      = mq[rv][0];
        rd_ok   = re && (mcnt[rv] > 0);
        wr_full = (mcnt[ivc] == DP);
        if (iv && ik[0] && mbusy[ivc]) mpro = 1'b1;
        if (iv && wr_full) movf = 1'b1;
        wr_ok = iv && !wr_full;
        if (rd_ok && fr[9]) mbusy[rv] = 1'b0;
        if (wr_ok && ik[0]) mbusy[ivc] = 1'b1;
        if (rd_ok) begin
            for (int s = 0; s < DP - 1; s++) mq[rv][s] = mq[rv][s+1];
            mcnt[rv]--;
        end
        if (wr_ok) begin
            mq[ivc][mcnt[ivc]] = fl;
            mcnt[ivc]++;
        end
        mcv = rd_ok; mcvc = rv;
        check_state();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // R4: read of an empty channel has no effect and gives no credit
        step(0, 0, 0, 1, 0);
        chk(!credit_valid, "R4 no credit on empty read", int'(credit_valid), 0);
        chk(vc_count == '0, "R4 counts unchanged", int'(vc_count), 0);

        // R7 and R6: fill channel 0 with an open packet, overflow it, then use channel 1
        step(1, 0, 1, 0, 0);
        step(1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        step(1, 0, 2, 0, 0);
        chk(overflow_err, "R6 overflow on full write", int'(overflow_err), 1);
        step(1, 1, 3, 0, 1);
        step(0, 0, 0, 1, 1);
        chk(credit_valid && credit_vc == 1'b1, "R7 other channel drains",
            int'({credit_valid, credit_vc}), 3);
        chk(int'(vc_count[0 +: CW]) == 3, "R7 blocked channel intact",
            int'(vc_count[0 +: CW]), 3);

        // R6: a pop in the same cycle does not make room for the write
        step(1, 0, 2, 1, 0);
        chk(int'(vc_count[0 +: CW]) == 2, "R6 write dropped despite pop",
            int'(vc_count[0 +: CW]), 2);

        // R10: write and pop on the same channel keep its count
        step(1, 1, 1, 0, 1);
        step(1, 1, 2, 1, 1);
        chk(int'(vc_count[CW +: CW]) == 1, "R10 count unchanged",
            int'(vc_count[CW +: CW]), 1);

        // R9: head on an owned channel
        step(1, 1, 1, 0, 0);
        chk(proto_err, "R9 head on owned channel", int'(proto_err), 1);

        // Sweep all 64 input combinations in reordered passes
        for (int pass = 0; pass < 4; pass++) begin
            do_reset();
            for (int i = 0; i < 64; i++) begin
                int p;
                p = (i * 37 + pass * 11) & 63;
                step(p[0], (p >> 1) & 1, (p >> 2) & 3, p[4], (p >> 5) & 1);
            end
            for (int i = 0; i < 8; i++) step(0, 0, 0, 1, i & 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule